// File: doc/BRIEF.md
# Quasi-Bidirectional Port Register

This block is one port of a microcontroller's parallel I/O, placed between the internal data bus and a group of external pins. Each bit has an output latch that is loaded from the bus. The bus reads back either the stored latch values or the current pin levels, and the caller picks the path with one of two separate strobes. There is no direction register. A latch bit at zero pulls its pin low. A latch bit at one releases the pin to an internal pull-up, so the pin can then be read as an input.

Read-modify-write sequences must use the latch path. If they read the pin path instead, a pin held low from outside would clear a latch bit that holds a one. Each bit also has an alternate-function output. That output can only pull the pin low while the latch bit is one. The raw pin level is always passed out as the alternate-function input. An analog-select input turns off the pull-up of a bit, but only for bits enabled by an instance parameter mask.

The pins are modelled as two controls per bit: a low-drive enable and a pull-up enable. The pin level comes back in on its own input. That input passes through a synchronizer before it reaches the read-pin path.

Top module: `qbio_port`

## Requirements
- R1: After reset every latch bit is one, `pin_drive_low` is all zero, and `pin_pull_en` is all one when `analog_sel` is zero.
- R2: When `wr_stb` is high at a rising clock edge, the latch loads `bus_wdata`. When `wr_stb` is low, the latch keeps its value.
- R3: While `rd_latch_stb` is high, `bus_rdata` equals the latch contents, whatever the pin levels are. This includes a pin held low while its latch bit is one.
- R4: While `rd_pin_stb` is high and `rd_latch_stb` is low, `bus_rdata` shows the pin levels sampled through a synchronizer of SYNC_STAGES flops (default 2). A pin change therefore appears after exactly two rising edges. A pin held low reads 0 even when its latch bit is one.
- R5: Bit i of `pin_drive_low` is 1 (pin actively pulled low) exactly when NOT(latch[i] AND alt_out[i]). A latch bit at zero always pulls the pin low.
- R6: `alt_in` equals `pin_in` at all times and does not depend on the latch.
- R7: Bit i of `pin_pull_en` is 0 exactly when analog_sel[i] and ANALOG_MASK[i] are both 1. Bits outside the mask ignore `analog_sel`.
- R8: When `wr_stb` and `rd_latch_stb` are high in the same cycle, `bus_rdata` returns the latch value from before the write. The new value appears after that clock edge.
- R9: With neither read strobe high, `bus_rdata` is zero. With both read strobes high, the latch path wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wdata | input | WIDTH | Internal bus write data |
| wr_stb | input | 1 | Write-to-latch strobe |
| rd_latch_stb | input | 1 | Read latch contents onto the bus |
| rd_pin_stb | input | 1 | Read synchronized pin levels onto the bus |
| bus_rdata | output | WIDTH | Read data toward the internal bus |
| alt_out | input | WIDTH | Alternate-function output levels |
| analog_sel | input | WIDTH | Per-bit analog select (turns off pull-up when masked in) |
| pin_in | input | WIDTH | Pin levels seen at the pads |
| pin_drive_low | output | WIDTH | Per-bit low-side drive enable |
| pin_pull_en | output | WIDTH | Per-bit pull-up enable |
| alt_in | output | WIDTH | Raw pin levels forwarded to alternate functions |

## Verification
The synchronizer assertion assumes `pin_in` is a clean level that is sampled once per clock. It only starts checking after enough edges since reset for every stage to hold a value captured after reset. The bench therefore changes pins only at falling edges and never while reset is active. The same-cycle read/write assertion expects strobes to be stable levels around the rising edge. The bench drives all strobes from the falling edge, and it reads the bus combinationally shortly after that edge, before the next rising edge. A second instance with an empty analog mask shows that analog selects outside the mask leave the pull-ups alone.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
   // read path selector
   typedef enum logic [1:0] {
      RSEL_NONE  = 2'b00,
      RSEL_PIN   = 2'b01,
      RSEL_LATCH = 2'b10
   } rsel_e;

   // latch path has priority over pin path
   function automatic rsel_e pick_read(input logic rd_latch, input logic rd_pin);
      if (rd_latch)    return RSEL_LATCH;
      else if (rd_pin) return RSEL_PIN;
      else             return RSEL_NONE;
   endfunction
endpackage

// File: rtl/qbio_latch_bank.sv
module qbio_latch_bank #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] latch_q
);
   initial begin
      assert (WIDTH >= 1) else $error("qbio_latch_bank: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      latch_q[i] <= 1'b1;
         else if (wr_stb) latch_q[i] <= wdata[i];
      end
   end

   // R2
   load_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> latch_q == $past(wdata));
   // R2
   hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(latch_q));
endmodule

// File: rtl/qbio_pin_sync.sv
module qbio_pin_sync #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_sync
);
   initial begin
      assert (SYNC_STAGES >= 2) else $error("qbio_pin_sync: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [SYNC_STAGES];

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '1;
            else        stage_q[s] <= pin_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '1;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign pin_sync = stage_q[SYNC_STAGES-1];

   // edges seen since reset, saturating at 2
   logic [1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             warm_q <= 2'd0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
   end

   if (SYNC_STAGES == 2) begin : g_lag_chk
      // R4
      two_clock_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (warm_q == 2'd2) |-> pin_sync == $past(pin_in, 2));
   end
endmodule

// File: rtl/qbio_pad_ctrl.sv
module qbio_pad_ctrl #(
   parameter int               WIDTH       = 8,
   parameter logic [WIDTH-1:0] ANALOG_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] alt_out,
   input  logic [WIDTH-1:0] analog_sel,
   output logic [WIDTH-1:0] pin_drive_low,
   output logic [WIDTH-1:0] pin_pull_en
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pad
      logic level;
      // pin can only go high when both the latch and the alternate output allow it
      assign level            = latch_q[i] & alt_out[i];
      assign pin_drive_low[i] = ~level;
      if (ANALOG_MASK[i]) begin : g_ana
         assign pin_pull_en[i] = ~analog_sel[i];
      end else begin : g_dig
         assign pin_pull_en[i] = 1'b1 | analog_sel[i];
      end
   end

   // R7
   pull_off_when_analog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((analog_sel & ANALOG_MASK) & pin_pull_en) == '0);
endmodule

// File: rtl/qbio_port.sv
module qbio_port #(
   parameter int               WIDTH       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] ANALOG_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] bus_wdata,
   input  logic             wr_stb,
   input  logic             rd_latch_stb,
   input  logic             rd_pin_stb,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic [WIDTH-1:0] alt_out,
   input  logic [WIDTH-1:0] analog_sel,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_drive_low,
   output logic [WIDTH-1:0] pin_pull_en,
   output logic [WIDTH-1:0] alt_in
);
   import qbio_pkg::*;

   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] pin_sync;
   rsel_e            rsel;

   qbio_latch_bank #(.WIDTH(WIDTH)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wdata   (bus_wdata),
      .latch_q (latch_q)
   );

   qbio_pin_sync #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .pin_sync (pin_sync)
   );

   qbio_pad_ctrl #(.WIDTH(WIDTH), .ANALOG_MASK(ANALOG_MASK)) u_pad (
      .clk           (clk),
      .rst_n         (rst_n),
      .latch_q       (latch_q),
      .alt_out       (alt_out),
      .analog_sel    (analog_sel),
      .pin_drive_low (pin_drive_low),
      .pin_pull_en   (pin_pull_en)
   );

   assign rsel = pick_read(rd_latch_stb, rd_pin_stb);

   always_comb begin
      unique case (rsel)
         RSEL_LATCH: bus_rdata = latch_q;
         RSEL_PIN:   bus_rdata = pin_sync;
         default:    bus_rdata = '0;
      endcase
   end

   assign alt_in = pin_in;

   // R8
   read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_latch_stb && $past(wr_stb)) |-> bus_rdata == $past(bus_wdata));
   // R5
   zero_latch_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (~latch_q & ~pin_drive_low) == '0);
endmodule

// File: tb/tb_qbio_port.sv
module tb_qbio_port;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] bus_wdata = '0;
   logic         wr_stb = 1'b0;
   logic         rd_latch_stb = 1'b0;
   logic         rd_pin_stb = 1'b0;
   logic [W-1:0] alt_out = '1;
   logic [W-1:0] analog_sel = '0;
   logic [W-1:0] pin_in = '1;
   logic [W-1:0] bus_rdata, pin_drive_low, pin_pull_en, alt_in;
   logic [W-1:0] rdata2, drv2, pull2, alt2;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   qbio_port #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .wr_stb(wr_stb),
      .rd_latch_stb(rd_latch_stb), .rd_pin_stb(rd_pin_stb), .bus_rdata(bus_rdata),
      .alt_out(alt_out), .analog_sel(analog_sel), .pin_in(pin_in),
      .pin_drive_low(pin_drive_low), .pin_pull_en(pin_pull_en), .alt_in(alt_in)
   );

   qbio_port #(.WIDTH(W), .ANALOG_MASK(8'h00)) dut_nomask (
      .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .wr_stb(wr_stb),
      .rd_latch_stb(rd_latch_stb), .rd_pin_stb(rd_pin_stb), .bus_rdata(rdata2),
      .alt_out(alt_out), .analog_sel(analog_sel), .pin_in(pin_in),
      .pin_drive_low(drv2), .pin_pull_en(pull2), .alt_in(alt2)
   );

   // {wdata, alt_out, pin_in, expected drive_low}
   localparam logic [31:0] VEC [6] = '{
      {8'hFF, 8'hFF, 8'hFF, 8'h00},
      {8'h00, 8'hFF, 8'h00, 8'hFF},
      {8'hA5, 8'hFF, 8'hA5, 8'h5A},
      {8'hFF, 8'h0F, 8'hF0, 8'hF0},
      {8'h3C, 8'hF0, 8'h0C, 8'hCF},
      {8'h81, 8'h7E, 8'hFF, 8'hFF}
   };

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_latch(input logic [W-1:0] v);
      @(negedge clk);
      bus_wdata = v; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic read_latch(output logic [W-1:0] v);
      rd_latch_stb = 1'b1; #1; v = bus_rdata; rd_latch_stb = 1'b0; #1;
   endtask

   task automatic read_pin(output logic [W-1:0] v);
      rd_pin_stb = 1'b1; #1; v = bus_rdata; rd_pin_stb = 1'b0; #1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      read_latch(v);
      chk("R1 latch", v, 8'hFF);
      chk("R1 drive_low", pin_drive_low, 8'h00);
      chk("R1 pull_en", pin_pull_en, 8'hFF);

      // vector table: R2 R3 R4 R5 R6
      for (int k = 0; k < 6; k++) begin
         write_latch(VEC[k][31:24]);
         alt_out = VEC[k][23:16];
         pin_in  = VEC[k][15:8];
         #1;
         chk("R5 drive_low", pin_drive_low, VEC[k][7:0]);
         chk("R6 alt_in", alt_in, VEC[k][15:8]);
         read_latch(v);
         chk("R2/R3 latch readback", v, VEC[k][31:24]);
         @(negedge clk); @(negedge clk);
         read_pin(v);
         chk("R4 pin readback", v, VEC[k][15:8]);
      end
      alt_out = '1;

      // R3 / R4: pin held low externally while latch is one
      write_latch(8'hFF);
      pin_in = 8'h00;
      @(negedge clk); @(negedge clk);
      read_latch(v);
      chk("R3 latch kept under low pin", v, 8'hFF);
      read_pin(v);
      chk("R4 pin low reads zero", v, 8'h00);

      // R4 lag: one edge is not enough, two are
      @(negedge clk);
      pin_in = 8'h5A;
      @(negedge clk);
      read_pin(v);
      chk("R4 one-edge lag", v, 8'h00);
      @(negedge clk);
      read_pin(v);
      chk("R4 two-edge lag", v, 8'h5A);

      // R2 no write without strobe
      @(negedge clk);
      bus_wdata = 8'h00;
      @(negedge clk); @(negedge clk);
      read_latch(v);
      chk("R2 hold without strobe", v, 8'hFF);

      // R8 write and read-latch in the same cycle
      @(negedge clk);
      bus_wdata = 8'h3C; wr_stb = 1'b1; rd_latch_stb = 1'b1;
      #1;
      chk("R8 old value during write", bus_rdata, 8'hFF);
      @(negedge clk);
      wr_stb = 1'b0;
      #1;
      chk("R8 new value after edge", bus_rdata, 8'h3C);
      rd_latch_stb = 1'b0;

      // R9 read mux
      #1;
      chk("R9 no strobe reads zero", bus_rdata, 8'h00);
      rd_latch_stb = 1'b1; rd_pin_stb = 1'b1; #1;
      chk("R9 latch has priority", bus_rdata, 8'h3C);
      rd_latch_stb = 1'b0; rd_pin_stb = 1'b0;

      // R7 analog select
      @(negedge clk);
      analog_sel = 8'h0F; #1;
      chk("R7 masked pull-ups off", pin_pull_en, 8'hF0);
      chk("R7 unmasked instance ignores select", pull2, 8'hFF);
      analog_sel = 8'h00;

      // R1 reset mid-run restores ones
      @(negedge clk);
      rst_n = 1'b0; #1; rst_n = 1'b1; #1;
      read_latch(v);
      chk("R1 latch after reset", v, 8'hFF);
      chk("R1 drive after reset", pin_drive_low, 8'h00);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule